// File: doc/BRIEF.md
# Burst Cache Line Fill Sequencer

This controller refills one 16-byte cache line over a 32-bit external bus. It issues a single burst of four dword reads and writes each returned dword into a line buffer. The bus speed is set at run time in r-b-w form. The first read beat lasts r clocks, each later read beat lasts b clocks, and a single write lasts w clocks. A complete refill therefore keeps the bus busy for r + 3b clocks. The burst always starts at the 16-byte-aligned base of the missing address and walks the dwords in ascending order.

The core side has three ports:
- A read-miss port, which starts refills.
- An access probe, which reports whether a core access must wait.
- A write port, which posts stores into a four-entry FIFO.

An access or a store that targets the line being refilled is held until the refill ends. A second read miss that arrives during a refill is also held until the refill ends. A store is held for any other reason only when all four posted entries are occupied. Posted stores go out on the bus in arrival order whenever no refill is running. A pending read miss takes precedence over a queued store.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, the following outputs are all low: `bus_req`, `bus_we`, `line_we`, `fill_done`, `line_valid` and every stall output.
- R2: A refill of miss address A reads the addresses (A & ~0xF) + 4k for k = 0,1,2,3, in that order. While beat k is captured, `line_idx` equals k and `bus_addr` equals (A & ~0xF) + 4k.
- R3: Call the cycle after the miss is accepted clock 1. Beats are captured (`line_we` high, `bus_take` high) exactly at clocks r, r+b, r+2b and r+3b, and at no other clock. `bus_req` is high and `bus_we` is low for the whole refill.
- R4: In the cycle after the fourth capture, `fill_done` pulses for one cycle and `line_valid` is high. In that cycle `line_addr` equals A & ~0xF. `line_valid` is low again from the first clock of the next refill.
- R5: During a refill, `acc_stall` is high for a valid access to the line being refilled and low for any other line. A store to the line being refilled raises `wr_stall`. Both stalls drop in the cycle that `fill_done` is high.
- R6: A read miss presented while the bus is idle is accepted with `rd_miss_stall` low. A read miss presented during a refill sees `rd_miss_stall` high until the `fill_done` cycle, and is accepted in that cycle.
- R7: A store is posted with `wr_stall` low while fewer than four stores are queued. A fifth store raises `wr_stall`.
- R8: Queued stores are written in FIFO order, back to back, once no refill is running. Each write lasts w clocks, with `bus_we` high, `bus_addr` and `bus_wdata` equal to the queued values, and `bus_take` high only in its last clock.
- R9: A value of 0 in `cfg_r`, `cfg_b` or `cfg_w` is treated as 1.
- R10: `line_data` equals `bus_rdata` in every capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_r | input | 4 | Clocks for the first read beat of a burst |
| cfg_b | input | 4 | Clocks for each later read beat |
| cfg_w | input | 4 | Clocks for one write |
| rd_miss_vld | input | 1 | Read miss request |
| rd_miss_addr | input | 32 | Byte address of the read miss |
| rd_miss_stall | output | 1 | Read miss not accepted this cycle |
| acc_vld | input | 1 | Core access probe valid |
| acc_addr | input | 32 | Core access byte address |
| acc_stall | output | 1 | Probed access must wait for the refill |
| wr_vld | input | 1 | Store request |
| wr_addr | input | 32 | Store byte address |
| wr_data | input | 32 | Store data |
| wr_stall | output | 1 | Store not accepted this cycle |
| bus_req | output | 1 | Bus transfer in progress |
| bus_we | output | 1 | Current transfer is a write |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled when `bus_take` is high |
| bus_take | output | 1 | Last clock of the current beat |
| line_we | output | 1 | Line buffer write strobe |
| line_idx | output | 2 | Dword index within the line |
| line_data | output | 32 | Dword written to the line buffer |
| fill_done | output | 1 | One-cycle pulse after a refill ends |
| line_valid | output | 1 | Line buffer holds a complete line |
| line_addr | output | 32 | Aligned base address of the line buffer |

## Verification
The interesting collision is the end of a refill arriving in the same cycle as other waiting work. That work can be a read miss held on the port, or stores queued during the refill. Both are provoked by holding a second miss from the second clock of a slow refill, and by posting four stores (and a fifth that must stall) during a refill with r = b = 15. The bench then checks that the held miss is accepted exactly in the `fill_done` cycle and that the next burst's first capture lands r clocks later. For the store case, it checks that the queued writes begin the cycle after `fill_done`, back to back at w clocks each, in posting order.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } lfs_state_e;
endpackage

// File: rtl/lfs_timer.sv
module lfs_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == TW'(1));
endmodule

// File: rtl/lfs_wbuf.sv
module lfs_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? ptr_inc(wp_q) : wp_q;
    rp_d  = pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic en;
    assign en = push && (wp_q == PW'(i));
    always_ff @(posedge clk) begin
      if (en) begin
        mem_a[i] <= push_addr;
        mem_d[i] <= push_data;
      end
    end
  end

  assign head_addr = mem_a[rp_q];
  assign head_data = mem_d[rp_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lfs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int TW         = 4,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_r,
  input  logic [TW-1:0]     cfg_b,
  input  logic [TW-1:0]     cfg_w,
  input  logic              rd_miss_vld,
  input  logic [ADDR_W-1:0] rd_miss_addr,
  output logic              rd_miss_stall,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_stall,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stall,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_take,
  output logic              line_we,
  output logic [1:0]        line_idx,
  output logic [DATA_W-1:0] line_data,
  output logic              fill_done,
  output logic              line_valid,
  output logic [ADDR_W-1:0] line_addr
);
  localparam int BYTES_PER = DATA_W / 8;
  localparam int BEATS     = LINE_BYTES / BYTES_PER;
  localparam int BW        = $clog2(BEATS);
  localparam int BOFF      = $clog2(BYTES_PER);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int TAG_W     = ADDR_W - OFF_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // clamp each timing field to a minimum of one clock
  logic [TW-1:0] r_eff, b_eff, w_eff;
  assign r_eff = (cfg_r == '0) ? TW'(1) : cfg_r;
  assign b_eff = (cfg_b == '0) ? TW'(1) : cfg_b;
  assign w_eff = (cfg_w == '0) ? TW'(1) : cfg_w;

  lfs_state_e         st_q, st_d;
  logic [BW-1:0]      beat_q, beat_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               done_q, done_d;
  logic               valid_q, valid_d;
  logic [ADDR_W-1:0]  cur_a_q, cur_a_d;
  logic [DATA_W-1:0]  cur_d_q, cur_d_d;

  logic t_load, t_last;
  logic [TW-1:0] t_val;
  logic wb_push, wb_pop, wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_ha;
  logic [DATA_W-1:0] wb_hd;

  logic filling, dispatch_ok, fill_go, wr_go, capture, last_beat;

  assign filling     = (st_q == ST_FILL);
  assign dispatch_ok = (st_q == ST_IDLE) || ((st_q == ST_WRITE) && t_last);
  assign fill_go     = dispatch_ok && rd_miss_vld;
  assign wr_go       = dispatch_ok && !rd_miss_vld && !wb_empty;
  assign capture     = filling && t_last;
  assign last_beat   = capture && (beat_q == BW'(BEATS - 1));

  always_comb begin
    t_load = 1'b0;
    t_val  = b_eff;
    if (fill_go) begin
      t_load = 1'b1;
      t_val  = r_eff;
    end else if (wr_go) begin
      t_load = 1'b1;
      t_val  = w_eff;
    end else if (capture && !last_beat) begin
      t_load = 1'b1;
    end
  end

  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    tag_d   = tag_q;
    done_d  = last_beat;
    valid_d = valid_q;
    cur_a_d = cur_a_q;
    cur_d_d = cur_d_q;
    case (st_q)
      ST_FILL: begin
        if (capture)   beat_d = beat_q + 1'b1;
        if (last_beat) begin
          st_d    = ST_IDLE;
          valid_d = 1'b1;
        end
      end
      ST_WRITE: if (t_last) st_d = ST_IDLE;
      default: ;
    endcase
    if (fill_go) begin
      st_d    = ST_FILL;
      beat_d  = '0;
      tag_d   = rd_miss_addr[ADDR_W-1:OFF_W];
      valid_d = 1'b0;
    end else if (wr_go) begin
      st_d    = ST_WRITE;
      cur_a_d = wb_ha;
      cur_d_d = wb_hd;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      tag_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      cur_a_q <= '0;
      cur_d_q <= '0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      tag_q   <= tag_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      cur_a_q <= cur_a_d;
      cur_d_q <= cur_d_d;
    end
  end

  lfs_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(t_load), .val(t_val), .last(t_last)
  );

  logic wr_hit_fill, acc_hit_fill;
  assign wr_hit_fill  = filling && (wr_addr[ADDR_W-1:OFF_W] == tag_q);
  assign acc_hit_fill = filling && (acc_addr[ADDR_W-1:OFF_W] == tag_q);

  assign wr_stall = wr_vld && (wb_full || wr_hit_fill);
  assign wb_push  = wr_vld && !wr_stall;
  assign wb_pop   = wr_go;

  lfs_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wb (
    .clk(clk), .rst_n(rst_i_n), .push(wb_push), .push_addr(wr_addr),
    .push_data(wr_data), .pop(wb_pop), .head_addr(wb_ha), .head_data(wb_hd),
    .empty(wb_empty), .full(wb_full)
  );

  assign rd_miss_stall = rd_miss_vld && !dispatch_ok;
  assign acc_stall     = acc_vld && acc_hit_fill;
  assign bus_req       = (st_q != ST_IDLE);
  assign bus_we        = (st_q == ST_WRITE);
  assign bus_addr      = filling ? {tag_q, beat_q, {BOFF{1'b0}}} : cur_a_q;
  assign bus_wdata     = cur_d_q;
  assign bus_take      = bus_req && t_last;
  assign line_we       = capture;
  assign line_idx      = 2'(beat_q);
  assign line_data     = bus_rdata;
  assign fill_done     = done_q;
  assign line_valid    = valid_q;
  assign line_addr     = {tag_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/lfs_chk.sv
module lfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_miss_vld,
  input logic       rd_miss_stall,
  input logic       acc_stall,
  input logic       wr_vld,
  input logic       wr_stall,
  input logic       bus_req,
  input logic       bus_we,
  input logic       bus_take,
  input logic       line_we,
  input logic [1:0] line_idx,
  input logic       fill_done,
  input logic       line_valid
);
  // R3: captures happen only on the last clock of a read beat
  assert_cap_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |-> (bus_take && bus_req && !bus_we));
  // R4: done follows the fourth capture
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && line_idx == 2'd3) |=> fill_done);
  // R4: done is a single-cycle pulse with the line valid
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);
  assert_done_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (line_valid && !bus_req));
  // R5: an access only waits while a refill occupies the bus
  assert_acc_only_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> (bus_req && !bus_we));
  // R6: a miss during a refill is held
  assert_miss_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss_vld && bus_req && !bus_we) |-> rd_miss_stall);
  // R7: no stall without a request
  assert_wr_stall_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |-> !wr_stall);
  // R8: a write beat occupies the bus
  assert_we_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_req);
endmodule

bind line_fill_seq lfs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_miss_vld(rd_miss_vld),
  .rd_miss_stall(rd_miss_stall), .acc_stall(acc_stall), .wr_vld(wr_vld),
  .wr_stall(wr_stall), .bus_req(bus_req), .bus_we(bus_we),
  .bus_take(bus_take), .line_we(line_we), .line_idx(line_idx),
  .fill_done(fill_done), .line_valid(line_valid)
);

// File: tb/sim_line_fill_seq.sv
`timescale 1ns/1ps
module sim_line_fill_seq;
  logic        clk, rst_n;
  logic [3:0]  cfg_r, cfg_b, cfg_w;
  logic        rd_miss_vld, acc_vld, wr_vld;
  logic [31:0] rd_miss_addr, acc_addr, wr_addr, wr_data;
  logic        rd_miss_stall, acc_stall, wr_stall;
  logic        bus_req, bus_we, bus_take, line_we, fill_done, line_valid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, line_data, line_addr;
  logic [1:0]  line_idx;

  int n_chk = 0;
  int n_err = 0;

  line_fill_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_r(cfg_r), .cfg_b(cfg_b), .cfg_w(cfg_w),
    .rd_miss_vld(rd_miss_vld), .rd_miss_addr(rd_miss_addr),
    .rd_miss_stall(rd_miss_stall), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_stall(acc_stall), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_stall(wr_stall), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_take(bus_take), .line_we(line_we),
    .line_idx(line_idx), .line_data(line_data), .fill_done(fill_done),
    .line_valid(line_valid), .line_addr(line_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  function automatic logic [31:0] wb_a(input int k);
    return 32'h8000_0000 + 32'(16 * k);
  endfunction
  function automatic logic [31:0] wb_d(input int k);
    return 32'hD000_0000 + 32'(k);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic start_miss(input logic [31:0] a, input int r, input int b,
                            input int w);
    @(negedge clk);
    cfg_r = 4'(r); cfg_b = 4'(b); cfg_w = 4'(w);
    rd_miss_vld = 1'b1; rd_miss_addr = a;
    #1;
    chk("R6", "idle miss not stalled", 32'(rd_miss_stall), 32'd0);
  endtask

  task automatic track_fill(input logic [31:0] a, input int r, input int b,
                            input bit probe, input bit qnext,
                            input logic [31:0] nxt, input bit wtest);
    int re, be, total;
    logic [31:0] base;
    re = (r == 0) ? 1 : r;   // R9
    be = (b == 0) ? 1 : b;
    total = re + 3 * be;
    base = a & ~32'hF;
    for (int c = 1; c <= total + 1; c++) begin
      @(negedge clk);
      if (c == 1) rd_miss_vld = 1'b0;
      if (probe) begin
        acc_vld  = 1'b1;
        acc_addr = (c % 2 == 1) ? base + 32'(4 * (c % 4)) : base + 32'h40;
      end
      if (qnext && c == 2) begin
        rd_miss_vld = 1'b1; rd_miss_addr = nxt;
      end
      if (wtest) begin
        wr_vld = (c >= 2 && c <= 7);
        if (c == 2) begin wr_addr = base + 32'd4; wr_data = 32'hBAD0_0000; end
        else if (c >= 3 && c <= 6) begin wr_addr = wb_a(c - 3); wr_data = wb_d(c - 3); end
        else if (c == 7) begin wr_addr = 32'h9000_0000; wr_data = 32'hBAD0_0001; end
      end
      #1;
      if (c == 1) chk("R4", "line_valid cleared at new fill", 32'(line_valid), 32'd0);
      if (c <= total) begin
        bit cap;
        int k;
        cap = (c >= re) && ((c - re) % be == 0);
        k = cap ? (c - re) / be : 0;
        chk("R3", $sformatf("capture strobe c=%0d", c), 32'(line_we), 32'(cap));
        chk("R3", "read burst on bus", {30'd0, bus_req, bus_we}, 32'd2);
        if (cap) begin
          chk("R2", "beat index", 32'(line_idx), 32'(k));
          chk("R2", "beat address", bus_addr, base + 32'(4 * k));
          chk("R10", "line data", line_data, mem_val(base + 32'(4 * k)));
          chk("R3", "bus_take at capture", 32'(bus_take), 32'd1);
        end
        if (probe)
          chk("R5", "access stall", 32'(acc_stall), 32'(c % 2 == 1));
        if (qnext && c >= 2)
          chk("R6", "held miss stalled", 32'(rd_miss_stall), 32'd1);
        if (wtest && c == 2) chk("R5", "store to filling line", 32'(wr_stall), 32'd1);
        if (wtest && c >= 3 && c <= 6) chk("R7", "posted store", 32'(wr_stall), 32'd0);
        if (wtest && c == 7) chk("R7", "fifth store full", 32'(wr_stall), 32'd1);
      end else begin
        chk("R4", "fill_done", 32'(fill_done), 32'd1);
        chk("R4", "line_valid", 32'(line_valid), 32'd1);
        chk("R4", "line_addr", line_addr, base);
        chk("R4", "bus idle at done", 32'(bus_req), 32'd0);
        if (probe) begin
          acc_addr = base;
          #0.1;
          chk("R5", "access released at done", 32'(acc_stall), 32'd0);
        end
        if (qnext) chk("R6", "held miss accepted at done", 32'(rd_miss_stall), 32'd0);
      end
    end
    acc_vld = 1'b0;
  endtask

  task automatic check_drain(input int w);
    for (int k = 0; k < 4; k++) begin
      for (int j = 1; j <= w; j++) begin
        @(negedge clk); #1;
        chk("R8", "write beat bus", {31'd0, bus_we}, 32'd1);
        chk("R8", $sformatf("write addr k=%0d", k), bus_addr, wb_a(k));
        chk("R8", "write data", bus_wdata, wb_d(k));
        chk("R8", "write take", 32'(bus_take), 32'(j == w));
      end
    end
    @(negedge clk); #1;
    chk("R8", "bus idle after drain", 32'(bus_req), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cfg_r = 4'd2; cfg_b = 4'd1; cfg_w = 4'd2;
    rd_miss_vld = 1'b0; rd_miss_addr = '0;
    acc_vld = 1'b0; acc_addr = '0;
    wr_vld = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset bus_req/we", {30'd0, bus_req, bus_we}, 32'd0);
    chk("R1", "reset line outputs", {29'd0, line_we, fill_done, line_valid}, 32'd0);
    chk("R1", "reset stalls", {29'd0, rd_miss_stall, acc_stall, wr_stall}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // fastest 2-1-2 bus, probe on
    start_miss(32'h1234_5678, 2, 1, 2);
    track_fill(32'h1234_5678, 2, 1, 1'b1, 1'b0, 32'd0, 1'b0);
    // R9: zero fields act as one clock
    start_miss(32'h0000_0ABC, 0, 0, 0);
    track_fill(32'h0000_0ABC, 0, 0, 1'b0, 1'b0, 32'd0, 1'b0);

    for (int i = 0; i < 20; i++) begin
      logic [31:0] a;
      int r, b;
      a = $urandom;
      r = $urandom_range(1, 15);
      b = $urandom_range(1, 15);
      start_miss(a, r, b, 2);
      track_fill(a, r, b, 1'($urandom_range(0, 1)), 1'b0, 32'd0, 1'b0);
    end

    // R6: miss held during a refill, accepted in the done cycle
    start_miss(32'h0000_1000, 3, 2, 2);
    track_fill(32'h0000_1000, 3, 2, 1'b0, 1'b1, 32'h0000_2024, 1'b0);
    track_fill(32'h0000_2024, 3, 2, 1'b0, 1'b0, 32'd0, 1'b0);

    // R7/R8: stores posted during a slow refill, drained afterwards
    start_miss(32'h0004_0010, 15, 15, 3);
    track_fill(32'h0004_0010, 15, 15, 1'b0, 1'b0, 32'd0, 1'b1);
    check_drain(3);

    summary();
  end
endmodule